// File: doc/BRIEF.md
# PS/2 Key Event Decoder

This block sits after a PS/2 frame receiver and turns the received scan-code bytes into whole key events. Each byte arrives with a one-cycle valid pulse. Two byte values act as prefixes and are never passed on directly:

- The extended marker 0xE0.
- The break marker 0xF0.

The decoder holds each prefix it sees until the next ordinary code byte arrives. It then attaches the held prefixes to that code and clears them.

The decoder also tracks the left shift key (code 0x12) and the right shift key (code 0x59). From these it reports whether either shift key is held down.

Each finished event loads the code, the extended flag and the break flag into the output registers together, and raises a ready flag. The ready flag stays high until the host pulses its read input. If a newer event arrives before the read, it overwrites the older one.

A build-time option keeps shift key events away from the host. With the option set, shift codes still update the shift state and still clear the held prefixes, but they raise no ready flag.

Top module: `ps2_keycode_decoder`

## Requirements
- R1: A valid byte equal to 0xE0 sets the held extended flag. It changes none of key_code, key_ext, key_rel or evt_ready.
- R2: A valid byte equal to 0xF0 sets the held break flag. It changes none of key_code, key_ext, key_rel or evt_ready.
- R3: A valid byte that is not a prefix produces an event on the next clock edge:
  - key_code takes the byte.
  - key_ext takes the held extended flag.
  - key_rel takes the held break flag.
  - All three are loaded in the same cycle, and evt_ready is set in that cycle too.
- R4: Both held prefix flags are cleared by every valid non-prefix byte, including a shift code that the hide option suppresses.
- R5: Code 0x12 sets the left shift state when no break prefix is held, and clears it when one is held. Code 0x59 does the same for the right shift state. The extended prefix has no effect on either state.
- R6: shift_on is 1 in the cycle after any byte that leaves the left or the right shift state set, and 0 when both states are clear.
- R7: evt_ready stays at 1 until host_read is sampled high in a cycle with no new event. It is then 0 from the next cycle on. A host_read while evt_ready is 0 has no effect.
- R8: Two cases keep evt_ready high while the new event replaces the old one:
  - A new event arrives while evt_ready is 1.
  - A new event arrives in the same cycle as host_read.
- R9: With HIDE_SHIFT=1, a valid 0x12 or 0x59 byte leaves evt_ready, key_code, key_ext and key_rel unchanged. The byte still updates the shift state. The default is HIDE_SHIFT=0.
- R10: Synchronous active-high reset clears the following to 0: key_code, key_ext, key_rel, evt_ready, shift_on and both held prefix flags.
- R11: In any cycle without an event, key_code, key_ext and key_rel keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | One-cycle strobe marking byte_in as a received scan byte |
| byte_in | input | 8 | Received scan byte |
| host_read | input | 1 | Host read acknowledge pulse |
| key_code | output | 8 | Code of the latest event |
| key_ext | output | 1 | The latest event was preceded by 0xE0 |
| key_rel | output | 1 | The latest event was preceded by 0xF0 (key break) |
| shift_on | output | 1 | Left or right shift currently held |
| evt_ready | output | 1 | An event is waiting for the host |

## Verification
Every one of the 254 non-prefix byte values is sent with each of the four prefix combinations: none, extended, break, and both. This shows that each held flag attaches only to the code that follows it and clears afterwards.

The two shift codes fall inside this sweep. Their make and break forms, with and without the extended prefix, tell apart correct per-key tracking from tracking that wrongly depends on the extended prefix.

Directed sequences cover the handshake corner cases:
- Back-to-back events with no read in between.
- An event arriving in the same cycle as a read.
- Reads while nothing is ready.
- A prefix byte arriving while the ready flag is low.

A second instance built with the hide option receives the same stream. This separates shift codes that are hidden from the host from codes whose shift state is simply lost.

// File: rtl/kbd_evt_pkg.sv
package kbd_evt_pkg;

    typedef enum logic {
        RDY_IDLE = 1'b0,
        RDY_HELD = 1'b1
    } rdy_state_e;

    typedef struct packed {
        logic ext;
        logic rel;
    } prefix_t;

    typedef struct packed {
        logic left;
        logic right;
    } shift_t;

endpackage

// File: rtl/kbd_prefix_track.sv
module kbd_prefix_track
    import kbd_evt_pkg::*;
#(
    parameter int              CODE_W   = 8,
    parameter logic [CODE_W-1:0] EXT_CODE = 8'hE0,
    parameter logic [CODE_W-1:0] REL_CODE = 8'hF0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [CODE_W-1:0] byte_in,
    output logic              code_evt,
    output logic              held_ext,
    output logic              held_rel
);

    prefix_t st_d, st_q;
    logic    is_ext, is_rel;

    assign is_ext = (byte_in == EXT_CODE);
    assign is_rel = (byte_in == REL_CODE);

    always_comb begin
        st_d     = st_q;
        code_evt = 1'b0;
        if (byte_vld) begin
            if (is_ext) begin
                st_d.ext = 1'b1;
            end else if (is_rel) begin
                st_d.rel = 1'b1;
            end else begin
                code_evt = 1'b1;
                st_d     = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign held_ext = st_q.ext;
    assign held_rel = st_q.rel;

    // R4: every ordinary code leaves both held flags clear
    a_r4_prefix_cleared: assert property (@(posedge clk) disable iff (rst)
        code_evt |=> (!held_ext && !held_rel));

    // R1: the extended marker is held for the next code
    a_r1_ext_held: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && byte_in == EXT_CODE) |=> held_ext);

endmodule

// File: rtl/kbd_shift_track.sv
module kbd_shift_track
    import kbd_evt_pkg::*;
#(
    parameter int              CODE_W  = 8,
    parameter logic [CODE_W-1:0] LS_CODE = 8'h12,
    parameter logic [CODE_W-1:0] RS_CODE = 8'h59
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              code_evt,
    input  logic [CODE_W-1:0] byte_in,
    input  logic              held_rel,
    output logic              is_shift,
    output logic              shift_on
);

    shift_t sh_d, sh_q;
    logic   hit_l, hit_r;

    assign hit_l    = (byte_in == LS_CODE);
    assign hit_r    = (byte_in == RS_CODE);
    assign is_shift = hit_l || hit_r;

    always_comb begin
        sh_d = sh_q;
        if (code_evt) begin
            if (hit_l) sh_d.left  = !held_rel;
            if (hit_r) sh_d.right = !held_rel;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '0;
        else     sh_q <= sh_d;
    end

    assign shift_on = sh_q.left || sh_q.right;

    // R5: a left shift make sets the state, a break clears it
    a_r5_left_make: assert property (@(posedge clk) disable iff (rst)
        (code_evt && hit_l && !held_rel) |=> shift_on);
    a_r5_right_make: assert property (@(posedge clk) disable iff (rst)
        (code_evt && hit_r && !held_rel) |=> shift_on);

endmodule

// File: rtl/kbd_event_hold.sv
module kbd_event_hold
    import kbd_evt_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              strobe,
    input  logic [CODE_W-1:0] code_in,
    input  logic              ext_in,
    input  logic              rel_in,
    input  logic              host_read,
    output logic [CODE_W-1:0] key_code,
    output logic              key_ext,
    output logic              key_rel,
    output logic              evt_ready
);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic              ext;
        logic              rel;
        rdy_state_e        rdy;
    } hold_t;

    hold_t hd_d, hd_q;

    always_comb begin
        hd_d = hd_q;
        if (strobe) begin
            hd_d.code = code_in;
            hd_d.ext  = ext_in;
            hd_d.rel  = rel_in;
            hd_d.rdy  = RDY_HELD;
        end else if (host_read) begin
            hd_d.rdy  = RDY_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hd_q <= '{code: '0, ext: 1'b0, rel: 1'b0, rdy: RDY_IDLE};
        end else begin
            hd_q <= hd_d;
        end
    end

    assign key_code  = hd_q.code;
    assign key_ext   = hd_q.ext;
    assign key_rel   = hd_q.rel;
    assign evt_ready = (hd_q.rdy == RDY_HELD);

    // R7: a read with no event drops the ready flag
    a_r7_read_clears: assert property (@(posedge clk) disable iff (rst)
        (host_read && !strobe) |=> !evt_ready);

    // R8: an event always leaves the ready flag set
    a_r8_strobe_sets: assert property (@(posedge clk) disable iff (rst)
        strobe |=> evt_ready);

    // R11: outputs hold without an event
    a_r11_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !strobe |=> ($stable(key_code) && $stable(key_ext) && $stable(key_rel)));

endmodule

// File: rtl/ps2_keycode_decoder.sv
module ps2_keycode_decoder
    import kbd_evt_pkg::*;
#(
    parameter int                CODE_W     = 8,
    parameter logic [CODE_W-1:0] EXT_CODE   = 8'hE0,
    parameter logic [CODE_W-1:0] REL_CODE   = 8'hF0,
    parameter logic [CODE_W-1:0] LS_CODE    = 8'h12,
    parameter logic [CODE_W-1:0] RS_CODE    = 8'h59,
    parameter bit                HIDE_SHIFT = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_vld,
    input  logic [CODE_W-1:0] byte_in,
    input  logic              host_read,
    output logic [CODE_W-1:0] key_code,
    output logic              key_ext,
    output logic              key_rel,
    output logic              shift_on,
    output logic              evt_ready
);

    logic code_evt, held_ext, held_rel, is_shift, strobe;

    kbd_prefix_track #(
        .CODE_W(CODE_W), .EXT_CODE(EXT_CODE), .REL_CODE(REL_CODE)
    ) prefix_i (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_in),
        .code_evt(code_evt), .held_ext(held_ext), .held_rel(held_rel)
    );

    kbd_shift_track #(
        .CODE_W(CODE_W), .LS_CODE(LS_CODE), .RS_CODE(RS_CODE)
    ) shift_i (
        .clk(clk), .rst(rst), .code_evt(code_evt), .byte_in(byte_in),
        .held_rel(held_rel), .is_shift(is_shift), .shift_on(shift_on)
    );

    generate
        if (HIDE_SHIFT) begin : g_hide
            assign strobe = code_evt && !is_shift;

            // R9: hidden shift codes never raise the ready flag
            a_r9_hidden_shift: assert property (@(posedge clk) disable iff (rst)
                (byte_vld && (byte_in == LS_CODE || byte_in == RS_CODE) && !evt_ready)
                |=> !evt_ready);
        end else begin : g_pass
            assign strobe = code_evt;
        end
    endgenerate

    kbd_event_hold #(
        .CODE_W(CODE_W)
    ) hold_i (
        .clk(clk), .rst(rst), .strobe(strobe), .code_in(byte_in),
        .ext_in(held_ext), .rel_in(held_rel), .host_read(host_read),
        .key_code(key_code), .key_ext(key_ext), .key_rel(key_rel),
        .evt_ready(evt_ready)
    );

    // R1 / R2: a prefix byte alone creates no event
    a_r2_prefix_silent: assert property (@(posedge clk) disable iff (rst)
        (byte_vld && (byte_in == EXT_CODE || byte_in == REL_CODE) && !host_read)
        |=> ($stable(evt_ready) && $stable(key_code)));

endmodule

// File: tb/ps2_keycode_decoder_tb_top.sv
module ps2_keycode_decoder_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       host_read = 1'b0;

    logic [7:0] key_code, t_key_code;
    logic       key_ext, key_rel, shift_on, evt_ready;
    logic       t_key_ext, t_key_rel, t_shift_on, t_evt_ready;

    int errors = 0;
    int checks = 0;

    // expected model
    bit       m_ext, m_rel, m_l, m_r;
    bit [7:0] m_code; bit m_e, m_rl, m_rdy;
    bit [7:0] t_code; bit t_e, t_rl, t_rdy;

    always #2 clk = ~clk;

    ps2_keycode_decoder dut_i (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_in),
        .host_read(host_read), .key_code(key_code), .key_ext(key_ext),
        .key_rel(key_rel), .shift_on(shift_on), .evt_ready(evt_ready)
    );

    ps2_keycode_decoder #(.HIDE_SHIFT(1'b1)) dut_trap_i (
        .clk(clk), .rst(rst), .byte_vld(byte_vld), .byte_in(byte_in),
        .host_read(host_read), .key_code(t_key_code), .key_ext(t_key_ext),
        .key_rel(t_key_rel), .shift_on(t_shift_on), .evt_ready(t_evt_ready)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_all();
        chk("R3 code", key_code, m_code);
        chk("R3/R4 ext", {7'd0, key_ext}, {7'd0, m_e});
        chk("R3/R4 rel", {7'd0, key_rel}, {7'd0, m_rl});
        chk("R7 ready", {7'd0, evt_ready}, {7'd0, m_rdy});
        chk("R6 shift", {7'd0, shift_on}, {7'd0, m_l | m_r});
        chk("R9 trap code", t_key_code, t_code);
        chk("R9 trap ext/rel", {6'd0, t_key_ext, t_key_rel}, {6'd0, t_e, t_rl});
        chk("R9 trap ready", {7'd0, t_evt_ready}, {7'd0, t_rdy});
        chk("R5 trap shift", {7'd0, t_shift_on}, {7'd0, m_l | m_r});
    endtask

    task automatic push(input logic [7:0] b, input bit rd);
        @(negedge clk);
        byte_vld = 1'b1; byte_in = b; host_read = rd;
        if (b == 8'hE0) begin
            m_ext = 1'b1;
            if (rd) begin m_rdy = 0; t_rdy = 0; end
        end else if (b == 8'hF0) begin
            m_rel = 1'b1;
            if (rd) begin m_rdy = 0; t_rdy = 0; end
        end else begin
            if (b == 8'h12) m_l = !m_rel;
            if (b == 8'h59) m_r = !m_rel;
            m_code = b; m_e = m_ext; m_rl = m_rel; m_rdy = 1'b1;
            if (b != 8'h12 && b != 8'h59) begin
                t_code = b; t_e = m_ext; t_rl = m_rel; t_rdy = 1'b1;
            end else if (rd) begin
                t_rdy = 1'b0;
            end
            m_ext = 1'b0; m_rel = 1'b0;
        end
        @(negedge clk);
        byte_vld = 1'b0; host_read = 1'b0;
        chk_all();
    endtask

    task automatic tick(input bit rd);
        @(negedge clk);
        host_read = rd;
        if (rd) begin m_rdy = 0; t_rdy = 0; end
        @(negedge clk);
        host_read = 1'b0;
        chk_all();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        chk("R10 reset code", key_code, 8'h00);
        chk("R10 reset flags", {4'd0, key_ext, key_rel, evt_ready, shift_on}, 8'h00);
        chk("R10 reset trap", {4'd0, t_key_ext, t_key_rel, t_evt_ready, t_shift_on}, 8'h00);
        chk_all();

        // R1 / R2: prefixes alone produce no event
        push(8'hE0, 1'b0);
        chk("R1 no event", {7'd0, evt_ready}, 8'h00);
        push(8'hF0, 1'b0);
        chk("R2 no event", {7'd0, evt_ready}, 8'h00);
        push(8'h1C, 1'b0);
        chk("R3 both prefixes", {6'd0, key_ext, key_rel}, 8'h03);
        tick(1'b1);

        // sweep all codes with all prefix combinations
        for (int c = 0; c < 256; c++) begin
            if (c == 8'hE0 || c == 8'hF0) continue;
            for (int p = 0; p < 4; p++) begin
                if (p[0]) push(8'hE0, 1'b0);
                if (p[1]) push(8'hF0, 1'b0);
                push(c[7:0], 1'b0);
                tick(1'b1);
            end
        end

        // R5: shift make/break sequences
        push(8'h12, 1'b0);
        push(8'h59, 1'b0);
        push(8'hF0, 1'b0); push(8'h12, 1'b0);
        chk("R6 right still held", {7'd0, shift_on}, 8'h01);
        push(8'hE0, 1'b0); push(8'hF0, 1'b0); push(8'h59, 1'b0);
        chk("R5 both released", {7'd0, shift_on}, 8'h00);
        chk("R9 hidden ready", {7'd0, t_evt_ready}, 8'h00);
        tick(1'b1);

        // R8: overwrite while ready, and event with simultaneous read
        push(8'h1C, 1'b0);
        push(8'h32, 1'b0);
        chk("R8 overwrite code", key_code, 8'h32);
        chk("R8 ready kept", {7'd0, evt_ready}, 8'h01);
        push(8'h21, 1'b1);
        chk("R8 read same cycle", {7'd0, evt_ready}, 8'h01);

        // R7 / R11: reads while idle change nothing
        tick(1'b1);
        tick(1'b1);
        chk("R11 code stable", key_code, 8'h21);
        tick(1'b0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule